// File: doc/BRIEF.md
# Accumulator Operand Addressing Unit

This block resolves the operand of an accumulator add for a small accumulator machine. A caller presents a 3-bit addressing mode, an address field, a register selector and the current program counter, and pulses `start`. The unit then evaluates the effective address, reads a register through its register-file read port and issues zero, one or two reads on a synchronous memory port. Read data returns one cycle after the request. Indirect mode chains two reads: the low bits of the first word returned become the address of the second read. The fetched operand is added to the internal accumulator, and `done` then pulses for one cycle.

Mode codes: 0 immediate, 1 direct, 2 indirect, 3 register, 4 register-indirect, 5 displacement, 6 PC-relative, 7 no-op. All address sums wrap modulo 2^ADDR_W. A register value used as an address contributes only its low ADDR_W bits. The register file read port is combinational: `rf_rd_data` must reflect `rf_rd_addr` in the same cycle.

Top module: `opaddr_unit`

## Requirements
- R1: After reset `acc` is 0 and `done`, `busy` and `mem_rd_en` are low.
- R2: Mode 0 (immediate) adds the address field, zero-extended to DATA_W, to `acc` and makes no memory read.
- R3: Mode 1 (direct) makes exactly one read at address A and adds the returned word to `acc`.
- R4: Mode 2 (indirect) makes two reads: the first at A, the second at the low ADDR_W bits of the first word. It adds the second word to `acc`.
- R5: Mode 3 (register) adds the selected register's value to `acc` and makes no memory read.
- R6: Mode 4 (register-indirect) makes one read at the low ADDR_W bits of the selected register and adds the returned word to `acc`.
- R7: Mode 5 (displacement) makes one read at (A + register) mod 2^ADDR_W and adds the returned word to `acc`.
- R8: Mode 6 (PC-relative) makes one read at (A + PC) mod 2^ADDR_W and adds the returned word to `acc`.
- R9: Mode 7 asserts `done` without changing `acc` and makes no memory read.
- R10: `done` is high for exactly one cycle per accepted operation. `acc` holds its final value in that cycle.
- R11: `start` is ignored while `busy` is high, and `acc` does not change while the unit is idle.
- R12: Counting rising edges from the edge that samples `start`, `done` is high after edge 1 for modes 0, 3 and 7, after edge 3 for mode 2, and after edge 2 for the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 3 | Addressing mode code |
| afield | input | ADDR_W | Address field A |
| reg_sel | input | REG_AW | Register selector |
| pc | input | ADDR_W | Current program counter |
| rf_rd_addr | output | REG_AW | Register file read address |
| rf_rd_data | input | DATA_W | Register file read data, same cycle |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Memory data, valid one cycle after the request |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| acc | output | DATA_W | Accumulator |

## Verification
Each result is due a fixed number of edges after `start` is sampled. It arrives one edge later for every memory read in the chain: one edge for modes without a read, two for a single read, three for indirect. After driving `start`, the bench counts rising edges. At each falling edge it samples `done`, the read requests and their addresses, and it compares the accumulator and the edge count with the model values in the cycle where `done` appears. One edge later it confirms that `done` has fallen. The sweep covers every mode against many address fields, registers and PC values, with wrapping sums included. A repeat of the indirect case holds `start` high throughout to show that the request is ignored while busy.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
   typedef enum logic [2:0] {
      AM_IMM  = 3'd0,
      AM_DIR  = 3'd1,
      AM_IND  = 3'd2,
      AM_REG  = 3'd3,
      AM_RIND = 3'd4,
      AM_DISP = 3'd5,
      AM_REL  = 3'd6,
      AM_NOP  = 3'd7
   } amode_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_EVAL = 3'd1,
      ST_RD1  = 3'd2,
      ST_RD2  = 3'd3,
      ST_FIN  = 3'd4
   } step_e;
endpackage

// File: rtl/opaddr_ea.sv
module opaddr_ea
   import opaddr_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 8,
   parameter bit IMM_SIGNED = 1'b0
) (
   input  amode_e              mode,
   input  logic [ADDR_W-1:0]   afield,
   input  logic [DATA_W-1:0]   rval,
   input  logic [ADDR_W-1:0]   pc,
   output logic [ADDR_W-1:0]   ea,
   output logic [DATA_W-1:0]   inline_opnd
);
   localparam int EXT_W = DATA_W - ADDR_W;

   logic [DATA_W-1:0] imm_ext;
   logic [ADDR_W-1:0] rlow;

   assign rlow = rval[ADDR_W-1:0];

   generate
      if (IMM_SIGNED) begin : g_imm_sx
         assign imm_ext = {{EXT_W{afield[ADDR_W-1]}}, afield};
      end else begin : g_imm_zx
         assign imm_ext = {{EXT_W{1'b0}}, afield};
      end
   endgenerate

   always_comb begin
      case (mode)
         AM_RIND: ea = rlow;
         AM_DISP: ea = afield + rlow;
         AM_REL:  ea = afield + pc;
         default: ea = afield;
      endcase
   end

   assign inline_opnd = (mode == AM_REG) ? rval : imm_ext;
endmodule

// File: rtl/opaddr_fsm.sv
module opaddr_fsm
   import opaddr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  amode_e mode_q,
   output logic   take,
   output logic   acc_we,
   output logic   acc_from_mem,
   output logic   rd_en,
   output logic   rd_chain,
   output logic   busy,
   output logic   done
);
   step_e st, st_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   always_comb begin
      st_nx        = st;
      take         = 1'b0;
      acc_we       = 1'b0;
      acc_from_mem = 1'b0;
      rd_en        = 1'b0;
      rd_chain     = 1'b0;
      done         = 1'b0;
      case (st)
         ST_IDLE: begin
            if (start) begin
               take  = 1'b1;
               st_nx = ST_EVAL;
            end
         end
         ST_EVAL: begin
            case (mode_q)
               AM_IMM, AM_REG: begin
                  acc_we = 1'b1;
                  st_nx  = ST_FIN;
               end
               AM_NOP: st_nx = ST_FIN;
               default: begin
                  rd_en = 1'b1;
                  st_nx = ST_RD1;
               end
            endcase
         end
         ST_RD1: begin
            if (mode_q == AM_IND) begin
               rd_en    = 1'b1;
               rd_chain = 1'b1;
               st_nx    = ST_RD2;
            end else begin
               acc_we       = 1'b1;
               acc_from_mem = 1'b1;
               st_nx        = ST_FIN;
            end
         end
         ST_RD2: begin
            acc_we       = 1'b1;
            acc_from_mem = 1'b1;
            st_nx        = ST_FIN;
         end
         ST_FIN: begin
            done  = 1'b1;
            st_nx = ST_IDLE;
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   assign busy = (st != ST_IDLE);
endmodule

// File: rtl/opaddr_acc.sv
module opaddr_acc #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] acc
);
   always_ff @(posedge clk) begin
      if (!rst_n)  acc <= '0;
      else if (we) acc <= acc + opnd;
   end
endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
   import opaddr_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 8,
   parameter int REG_AW     = 3,
   parameter bit IMM_SIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        mode,
   input  logic [ADDR_W-1:0] afield,
   input  logic [REG_AW-1:0] reg_sel,
   input  logic [ADDR_W-1:0] pc,
   output logic [REG_AW-1:0] rf_rd_addr,
   input  logic [DATA_W-1:0] rf_rd_data,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] acc
);
   initial begin
      assert (ADDR_W >= 2 && ADDR_W < DATA_W)
         else $error("ADDR_W must be at least 2 and below DATA_W");
      assert (REG_AW >= 1 && REG_AW <= 8)
         else $error("REG_AW out of range");
   end

   amode_e            mode_q;
   logic [ADDR_W-1:0] afield_q, pc_q;
   logic [REG_AW-1:0] rsel_q;
   logic              take, acc_we, acc_from_mem, rd_chain;
   logic [ADDR_W-1:0] ea;
   logic [DATA_W-1:0] inline_opnd, opnd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= AM_NOP;
         afield_q <= '0;
         pc_q     <= '0;
         rsel_q   <= '0;
      end else if (take) begin
         mode_q   <= amode_e'(mode);
         afield_q <= afield;
         pc_q     <= pc;
         rsel_q   <= reg_sel;
      end
   end

   assign rf_rd_addr = rsel_q;

   opaddr_ea #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_SIGNED(IMM_SIGNED)
   ) u_ea (
      .mode(mode_q), .afield(afield_q), .rval(rf_rd_data), .pc(pc_q),
      .ea(ea), .inline_opnd(inline_opnd)
   );

   opaddr_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_q(mode_q),
      .take(take), .acc_we(acc_we), .acc_from_mem(acc_from_mem),
      .rd_en(mem_rd_en), .rd_chain(rd_chain), .busy(busy), .done(done)
   );

   assign mem_rd_addr = rd_chain ? mem_rd_data[ADDR_W-1:0] : ea;
   assign opnd        = acc_from_mem ? mem_rd_data : inline_opnd;

   opaddr_acc #(.DATA_W(DATA_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .we(acc_we), .opnd(opnd), .acc(acc)
   );
endmodule

// File: rtl/opaddr_chk.sv
module opaddr_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [2:0]        mode,
   input logic              busy,
   input logic              done,
   input logic              mem_rd_en,
   input logic [DATA_W-1:0] acc
);
   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R11
   idle_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(acc));

   // R11
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && !done) |=> busy);

   // R3
   read_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> busy);

   // R2
   imm_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == 3'd0) |=> !mem_rd_en);

   // R9
   nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == 3'd7) |=> (!mem_rd_en && $stable(acc)));
endmodule

bind opaddr_unit opaddr_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
   .done(done), .mem_rd_en(mem_rd_en), .acc(acc)
);

// File: tb/sim_opaddr_unit.sv
`timescale 1ns/1ps
module sim_opaddr_unit;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 8;
   localparam int REG_AW = 3;
   localparam int NMEM   = 1 << ADDR_W;
   localparam int NREG   = 1 << REG_AW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [2:0]        mode = '0;
   logic [ADDR_W-1:0] afield = '0;
   logic [REG_AW-1:0] reg_sel = '0;
   logic [ADDR_W-1:0] pc = '0;
   logic [REG_AW-1:0] rf_rd_addr;
   logic [DATA_W-1:0] rf_rd_data;
   logic              mem_rd_en;
   logic [ADDR_W-1:0] mem_rd_addr;
   logic [DATA_W-1:0] mem_rd_data = '0;
   logic              busy, done;
   logic [DATA_W-1:0] acc;

   logic [DATA_W-1:0] mem [NMEM];
   logic [DATA_W-1:0] rf  [NREG];
   logic [DATA_W-1:0] acc_exp = '0;
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   opaddr_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .afield(afield),
      .reg_sel(reg_sel), .pc(pc), .rf_rd_addr(rf_rd_addr),
      .rf_rd_data(rf_rd_data), .mem_rd_en(mem_rd_en),
      .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .busy(busy), .done(done), .acc(acc)
   );

   assign rf_rd_data = rf[rf_rd_addr];

   always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input int m);
      case (m)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         5: return "R7";
         6: return "R8";
         default: return "R9";
      endcase
   endfunction

   // called at a falling edge; returns at the falling edge after done fell
   task automatic run_op(input int m, input int a, input int r, input int p,
                         input bit hold_start);
      int lat_exp, rd_exp, k, nrd;
      logic [ADDR_W-1:0] ea1, ea2, got1, got2;
      logic [DATA_W-1:0] opnd;
      string rq;
      rq = req_of(m);
      ea1 = a[ADDR_W-1:0];
      ea2 = '0;
      opnd = '0;
      case (m)
         0: begin opnd = {{(DATA_W-ADDR_W){1'b0}}, ea1}; lat_exp = 1; rd_exp = 0; end
         1: begin opnd = mem[ea1]; lat_exp = 2; rd_exp = 1; end
         2: begin ea2 = mem[ea1][ADDR_W-1:0]; opnd = mem[ea2]; lat_exp = 3; rd_exp = 2; end
         3: begin opnd = rf[r]; lat_exp = 1; rd_exp = 0; end
         4: begin ea1 = rf[r][ADDR_W-1:0]; opnd = mem[ea1]; lat_exp = 2; rd_exp = 1; end
         5: begin ea1 = ADDR_W'(a + int'(rf[r][ADDR_W-1:0])); opnd = mem[ea1]; lat_exp = 2; rd_exp = 1; end
         6: begin ea1 = ADDR_W'(a + p); opnd = mem[ea1]; lat_exp = 2; rd_exp = 1; end
         default: begin lat_exp = 1; rd_exp = 0; end
      endcase
      start = 1'b1; mode = 3'(m); afield = ADDR_W'(a);
      reg_sel = REG_AW'(r); pc = ADDR_W'(p);
      @(posedge clk);
      k = 0; nrd = 0; got1 = '0; got2 = '0;
      forever begin
         @(negedge clk);
         if (k == 0) begin
            if (hold_start) begin mode = 3'd0; afield = '1; end
            else start = 1'b0;
         end
         if (done || k > 8) break;
         if (mem_rd_en) begin
            if (nrd == 0) got1 = mem_rd_addr; else got2 = mem_rd_addr;
            nrd++;
         end
         @(posedge clk);
         k++;
      end
      start = 1'b0;
      if (m != 7) acc_exp = acc_exp + opnd;
      check(acc == acc_exp, rq, "acc", acc, acc_exp);
      check(k == lat_exp, "R12", "latency", k, lat_exp);
      check(nrd == rd_exp, rq, "read count", nrd, rd_exp);
      if (rd_exp > 0) check(got1 == ea1, rq, "first address", got1, ea1);
      if (rd_exp > 1) check(got2 == ea2, "R4", "chained address", got2, ea2);
      @(posedge clk);
      @(negedge clk);
      check(done == 1'b0, "R10", "done width", done, 0);
      if (hold_start) begin
         check(busy == 1'b0, "R11", "busy after held start", busy, 0);
         check(acc == acc_exp, "R11", "acc after held start", acc, acc_exp);
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NMEM; i++) mem[i] = DATA_W'(i * 251 + 16'h1357);
      for (int i = 0; i < NREG; i++) rf[i] = DATA_W'(16'h00F3 + i * 16'h2345);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(acc == 0, "R1", "reset acc", acc, 0);
      check(done == 0, "R1", "reset done", done, 0);
      check(busy == 0, "R1", "reset busy", busy, 0);
      check(mem_rd_en == 0, "R1", "reset read", mem_rd_en, 0);
      repeat (3) @(negedge clk);
      check(acc == 0, "R11", "idle acc", acc, 0);
      for (int m = 0; m < 8; m++) begin
         for (int a = 0; a < NMEM; a += 15)
            run_op(m, a, (a / 15) % NREG, (a * 3 + 200) % NMEM, 1'b0);
         run_op(m, 255, 7, 255, 1'b0);
      end
      // wrap corners for displacement and relative sums
      run_op(5, 250, 2, 0, 1'b0);
      run_op(6, 250, 0, 10, 1'b0);
      run_op(6, 0, 0, 0, 1'b0);
      // start held high during an indirect operation
      run_op(2, 77, 1, 0, 1'b1);
      run_op(5, 3, 6, 9, 1'b1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule